// File: doc/BRIEF.md
# Dual-Frequency Quad-Phase NCO

This block is a numerically controlled oscillator. A wide phase accumulator adds a frequency tuning word on every clock cycle. Two tuning words and four phase offsets are held at the inputs, and select lines choose among them while the oscillator runs.

The top bits of the accumulator plus the chosen phase offset form the output phase, which is registered and carries a valid flag. A phase-to-amplitude stage downstream turns it into a waveform. The output frequency is the tuning word times the clock frequency, divided by two to the power of the accumulator width. One output LSB is 2π divided by 2 to the power of the phase width.

Three controls set the run state. A reset hold keeps the oscillator at phase zero. A sleep hold freezes it. A clear request zeroes the accumulator once. Bringing the oscillator up means dropping all three controls. Stopping it means raising only the reset hold.

Top module: `nco_dual_quad`

## Requirements
- R1: While `rst_n` is low, `phase_out` is 0 and `phase_vld` is 0, and the accumulator is zero.
- R2: When no hold or clear acts, the accumulator advances by the selected tuning word, modulo 2^ACC_W, on every clock edge.
- R3: After each clock edge, `phase_out` equals the top PH_W bits of the accumulator value held before that edge, plus the selected offset sampled at that edge, modulo 2^PH_W.
- R4: `tune_sel` = 0 selects `tune_a` and `tune_sel` = 1 selects `tune_b`. A change applies from the next accumulator update, and the phase already accumulated is kept.
- R5: `ofs_sel` values 0, 1, 2 and 3 select `ofs0`, `ofs1`, `ofs2` and `ofs3`. A change applies at the next output update.
- R6: While `hold_rst` is high, the accumulator is loaded with zero on every edge, and `phase_vld` is 0 after that edge.
- R7: While `hold_sleep` is high and neither the reset hold nor a clear acts, the accumulator keeps its value, and `phase_vld` is 0 after that edge.
- R8: A rising `acc_clr` zeroes the accumulator on one edge only. If `acc_clr` stays high, counting resumes on the following edges.
- R9: Priority runs reset hold, then clear, then sleep. A clear edge seen while the reset hold is high is used up.
- R10: The selected tuning word must not exceed 2^(ACC_W-1), which is half the clock rate, whenever the oscillator runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tune_a | input | ACC_W | Tuning word chosen by tune_sel = 0 |
| tune_b | input | ACC_W | Tuning word chosen by tune_sel = 1 |
| ofs0 | input | PH_W | Phase offset chosen by ofs_sel = 0 |
| ofs1 | input | PH_W | Phase offset chosen by ofs_sel = 1 |
| ofs2 | input | PH_W | Phase offset chosen by ofs_sel = 2 |
| ofs3 | input | PH_W | Phase offset chosen by ofs_sel = 3 |
| tune_sel | input | 1 | Tuning word select |
| ofs_sel | input | 2 | Phase offset select |
| hold_rst | input | 1 | Hold the accumulator at zero and mark the output invalid |
| hold_sleep | input | 1 | Freeze the accumulator and mark the output invalid |
| acc_clr | input | 1 | Rising edge zeroes the accumulator once |
| phase_out | output | PH_W | Output phase |
| phase_vld | output | 1 | Output phase valid |

## Verification
The assertions assume that software never programs a tuning word above half the clock rate while the oscillator runs. They also assume the controls are synchronous to `clk`. The stimulus keeps every tuning word it drives at or below 2^(ACC_W-1), including the limit value itself. It changes inputs only just after a rising edge. The bench uses a narrow build, a 16-bit accumulator with 8-bit phase, so that every offset value can be swept on every select. The accumulator is observed only through `phase_out`, so the tuning words are chosen large enough to carry into the top bits within a few cycles.

// File: rtl/nco_dual_quad.sv
module nco_dual_quad #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] tune_a,
  input  logic [ACC_W-1:0] tune_b,
  input  logic [PH_W-1:0]  ofs0,
  input  logic [PH_W-1:0]  ofs1,
  input  logic [PH_W-1:0]  ofs2,
  input  logic [PH_W-1:0]  ofs3,
  input  logic             tune_sel,
  input  logic [1:0]       ofs_sel,
  input  logic             hold_rst,
  input  logic             hold_sleep,
  input  logic             acc_clr,
  output logic [PH_W-1:0]  phase_out,
  output logic             phase_vld
);
  localparam logic [ACC_W-1:0] NYQ = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] acc, step;
  logic [PH_W-1:0]  ofs;
  logic             clr_q, clr_edge;

  assign step     = tune_sel ? tune_b : tune_a;
  assign clr_edge = acc_clr & ~clr_q;

  always_comb begin
    case (ofs_sel)
      2'd0:    ofs = ofs0;
      2'd1:    ofs = ofs1;
      2'd2:    ofs = ofs2;
      default: ofs = ofs3;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      clr_q     <= 1'b0;
      phase_out <= '0;
      phase_vld <= 1'b0;
    end else begin
      clr_q     <= acc_clr;
      phase_out <= acc[ACC_W-1 -: PH_W] + ofs;
      phase_vld <= ~hold_rst & ~hold_sleep;
      if (hold_rst)        acc <= '0;
      else if (clr_edge)   acc <= '0;
      else if (!hold_sleep) acc <= acc + step;
    end
  end

  assert_run_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_rst && !clr_edge && !hold_sleep) |=> acc == $past(acc) + $past(step));

  assert_rst_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_rst |=> (acc == '0) && !phase_vld);

  assert_sleep_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_sleep && !hold_rst && !clr_edge) |=> $stable(acc) && !phase_vld);

  assert_clr_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_edge |=> (acc == '0) && clr_q);

  assert_fword_nyquist_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_rst && !hold_sleep) |-> step <= NYQ);
endmodule

// File: tb/sim_nco_dual_quad.sv
module sim_nco_dual_quad;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] ta = '0, tb = '0;
  logic [PW-1:0] pw [4];
  logic tsel = 1'b0;
  logic [1:0] psel = 2'd0;
  logic hrst = 1'b1, hslp = 1'b1, clr = 1'b1;
  logic [PW-1:0] pout;
  logic pvld;

  int vectors = 0, fails = 0;
  logic [AW-1:0] m_acc = '0;
  logic m_clrq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nco_dual_quad #(.ACC_W(AW), .PH_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .tune_a(ta), .tune_b(tb),
    .ofs0(pw[0]), .ofs1(pw[1]), .ofs2(pw[2]), .ofs3(pw[3]),
    .tune_sel(tsel), .ofs_sel(psel), .hold_rst(hrst), .hold_sleep(hslp),
    .acc_clr(clr), .phase_out(pout), .phase_vld(pvld));

  task automatic chk(string req, logic [PW-1:0] eo, logic ev);
    vectors++;
    if (pout !== eo || pvld !== ev) begin
      fails++;
      $display("FAIL %s: phase_out=%0d vld=%0b expected phase_out=%0d vld=%0b",
               req, pout, pvld, eo, ev);
    end
  endtask

  task automatic step(string req);
    logic [PW-1:0] eo;
    logic ev;
    logic [AW-1:0] inc;
    @(posedge clk);
    #1;
    eo  = PW'((m_acc >> (AW - PW)) + pw[psel]);
    ev  = !hrst && !hslp;
    inc = tsel ? tb : ta;
    if (hrst)                m_acc = '0;
    else if (clr && !m_clrq) m_acc = '0;
    else if (!hslp)          m_acc = m_acc + inc;
    m_clrq = clr;
    chk(req, eo, ev);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    pw[0] = 8'd0; pw[1] = 8'd0; pw[2] = 8'd0; pw[3] = 8'd0;
    #(CLK_PERIOD * 3);
    chk("R1", '0, 1'b0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step("R6 R9 power-up holds");
    hrst = 1'b0; hslp = 1'b0; clr = 1'b0;
    ta = 16'h0123;
    for (int i = 0; i < 6; i++) step("R2");
    foreach (ta[k]) begin
      ta = AW'(16'h8000 >> k);
      for (int i = 0; i < 5; i++) step("R2 R10 tuning sweep");
    end
    ta = 16'h8000;
    for (int i = 0; i < 6; i++) step("R10 limit word");
    ta = 16'h0311;
    for (int p = 0; p < 4; p++) begin
      psel = 2'(p);
      for (int v = 0; v < 256; v++) begin
        pw[p] = 8'(v);
        pw[(p + 1) % 4] = 8'(255 - v);
        step("R3 R5 offset sweep");
      end
    end
    ta = 16'h0100; tb = 16'h2a05;
    for (int i = 0; i < 40; i++) begin
      tsel = i[0];
      psel = 2'(i >> 1);
      step("R4 select toggling");
    end
    tsel = 1'b1;
    for (int i = 0; i < 6; i++) step("R4");
    hslp = 1'b1;
    for (int i = 0; i < 8; i++) step("R7 sleep");
    hslp = 1'b0;
    for (int i = 0; i < 4; i++) step("R7 resume");
    clr = 1'b1;
    for (int i = 0; i < 8; i++) step("R8 clear held");
    clr = 1'b0;
    for (int i = 0; i < 3; i++) step("R8");
    clr = 1'b1; hslp = 1'b1;
    step("R9 clear over sleep");
    step("R9");
    clr = 1'b0; hslp = 1'b0;
    for (int c = 0; c < 16; c++) begin
      hrst = c[0]; hslp = c[1]; clr = c[2];
      tsel = c[3];
      for (int i = 0; i < 3; i++) step("R9 control combos");
    end
    hrst = 1'b0; hslp = 1'b0; clr = 1'b0;
    for (int i = 0; i < 5; i++) step("R2 R3 after combos");
    hrst = 1'b1;
    for (int i = 0; i < 3; i++) step("R6 stop");
    #1;
    rst_n = 1'b0;
    #2;
    chk("R1 async", '0, 1'b0);
    summary();
  end
endmodule